// File: doc/BRIEF.md
# Bit-Serial Arithmetic and Logic Unit With Status Flags

This block computes one arithmetic or logic operation on two operands by walking through them one bit per clock, lowest bit first, through a single-bit adder and logic cell. A full operation therefore takes a fixed number of cycles equal to the operand width. The single exception is the left shift by one, which is formed as a parallel rewiring of the first operand when the operation is launched. It still takes the same fixed number of cycles, so every operation has the same latency.

The block keeps three status flags: carry, zero and negative. Add and subtract each come in two forms. One form starts from a fixed carry-in. The other starts from the stored carry, so that wider numbers can be chained across several operations. The result register and the flags change only at the cycle in which the operation completes. A one-cycle completion pulse marks that cycle.

A controller pulses `start` with the operands and the operation code. It then waits for `done` and reads `result` and the flags.

Top module: `bsalu_core`

## Requirements
- R1: A `start` sampled high while `busy` is low captures `op`, `opa` and `opb`. `busy` is high for the next WIDTH cycles. `done` is high for exactly one cycle, the cycle after the WIDTH-th capture-following clock edge, and at that cycle `busy` is already low.
- R2: Operation code 0 (add) gives `result` = (opa + opb) mod 2^WIDTH. `carry_flag` becomes the carry out of the top bit.
- R3: Operation code 1 (add with carry) gives `result` = (opa + opb + carry_flag) mod 2^WIDTH. It uses the carry flag held before the operation, and `carry_flag` becomes the new carry out.
- R4: Operation code 2 (subtract) computes opa + ~opb + 1. `result` is opa − opb mod 2^WIDTH, and `carry_flag` is 1 exactly when no borrow occurred (opa ≥ opb).
- R5: Operation code 3 (subtract with carry) computes opa + ~opb + carry_flag. It uses the carry flag held before the operation, and `carry_flag` becomes the carry out.
- R6: Operation codes 4 (bitwise AND) and 5 (bitwise OR) give the bitwise result and leave `carry_flag` unchanged. An OR with opb = 0 returns opa unchanged.
- R7: Operation codes 6 and 7 (shift left by one) give `result` = opa shifted left by one with a 0 in bit 0. `carry_flag` becomes opa's top bit, and opb has no effect.
- R8: At each completion, `zero_flag` is 1 exactly when the new `result` is all zeros.
- R9: At each completion, `neg_flag` equals the top bit of the new `result`.
- R10: `result` and all three flags keep their values in every cycle except the completion cycle.
- R11: A `start` sampled while `busy` is high is ignored. The running operation finishes with its original operands and operation code.
- R12: After reset, `result`, all flags, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, taken only while idle |
| op | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6/7 shift left) |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| result | output | WIDTH | Result register, updated at completion |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while an operation is in flight |
| carry_flag | output | 1 | Stored carry (1 = no borrow after a subtraction) |
| zero_flag | output | 1 | Last result was zero |
| neg_flag | output | 1 | Last result had its top bit set |

## Verification
The assertions assume that `op`, `opa` and `opb` carry defined values whenever `start` is high. They also assume that the controller reads the outputs only at the `done` pulse. The bench drives inputs on falling edges and holds `start` for one cycle per launch. The one exception is a deliberate second `start` in the middle of an operation, which tests that it is ignored. The bench's reference model tracks the carry across operations, so the carry-in variants are checked against the carry that earlier operations actually left behind.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADDC = 3'd1,
      OP_SUB  = 3'd2,
      OP_SUBC = 3'd3,
      OP_AND  = 3'd4,
      OP_OR   = 3'd5,
      OP_SHL  = 3'd6,
      OP_SHLX = 3'd7
   } alu_op_e;

   function automatic logic op_is_arith(alu_op_e o);
      return ~o[2];
   endfunction

   function automatic logic op_is_sub(alu_op_e o);
      return ~o[2] & o[1];
   endfunction

   function automatic logic op_is_shl(alu_op_e o);
      return o[2] & o[1];
   endfunction

   function automatic logic op_is_logic(alu_op_e o);
      return o[2] & ~o[1];
   endfunction

endpackage

// File: rtl/bsalu_bitcell.sv
module bsalu_bitcell
   import bsalu_pkg::*;
(
   input  alu_op_e op,
   input  logic    a,
   input  logic    b,
   input  logic    cin,
   output logic    y,
   output logic    cout
);

   logic bx;

   always_comb begin
      bx   = op_is_sub(op) ? ~b : b;
      y    = 1'b0;
      cout = cin;
      unique case (op)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
            y    = a ^ bx ^ cin;
            cout = (a & bx) | (cin & (a ^ bx));
         end
         OP_AND: y = a & b;
         OP_OR:  y = a | b;
         default: begin
            y    = 1'b0;
            cout = cin;
         end
      endcase
   end

endmodule

// File: rtl/bsalu_seq.sv
module bsalu_seq #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic launch,
   output logic busy,
   output logic last,
   output logic done
);

   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

   logic [CW-1:0] cnt;

   assign launch = start & ~busy;
   assign last   = busy & (cnt == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (launch) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            cnt <= cnt + CW'(1);
         end
      end
   end

   assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= LAST_CNT));
   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);

endmodule

// File: rtl/bsalu_flags.sv
module bsalu_flags
   import bsalu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit ZERO_SERIAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             step,
   input  logic             last,
   input  logic             done_i,
   input  alu_op_e          op_q,
   input  logic             bit_in,
   input  logic [WIDTH-1:0] final_res,
   input  logic             c_new,
   output logic             carry_q,
   output logic             zero_q,
   output logic             neg_q
);

   logic zero_next;

   generate
      if (ZERO_SERIAL) begin : g_zero_serial
         logic zacc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      zacc <= 1'b0;
            else if (launch) zacc <= 1'b0;
            else if (step)   zacc <= zacc | bit_in;
         end
         assign zero_next = op_is_shl(op_q) ? ~|final_res : ~(zacc | bit_in);
      end else begin : g_zero_parallel
         assign zero_next = ~|final_res;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
         zero_q  <= 1'b0;
         neg_q   <= 1'b0;
      end else if (last) begin
         zero_q <= zero_next;
         neg_q  <= final_res[WIDTH-1];
         if (!op_is_logic(op_q)) carry_q <= c_new;
      end
   end

   assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |-> $stable({carry_q, zero_q, neg_q}));

endmodule

// File: rtl/bsalu_core.sv
module bsalu_core
   import bsalu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit ZERO_SERIAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       op,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] result,
   output logic             done,
   output logic             busy,
   output logic             carry_flag,
   output logic             zero_flag,
   output logic             neg_flag
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bsalu_core: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e          op_in, op_q;
   logic [WIDTH-1:0] sa, sb, sr, out_q, fin;
   logic             run_c, cin0, y, cout;
   logic             launch, last;

   assign op_in = alu_op_e'(op);

   bsalu_seq #(.WIDTH(WIDTH)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .launch(launch), .busy(busy), .last(last), .done(done)
   );

   bsalu_bitcell u_cell (
      .op(op_q), .a(sa[0]), .b(sb[0]), .cin(run_c), .y(y), .cout(cout)
   );

   always_comb begin
      unique case (op_in)
         OP_ADD:          cin0 = 1'b0;
         OP_SUB:          cin0 = 1'b1;
         OP_ADDC, OP_SUBC: cin0 = carry_flag;
         OP_SHL, OP_SHLX: cin0 = opa[WIDTH-1];
         default:         cin0 = 1'b0;
      endcase
   end

   assign fin = op_is_shl(op_q) ? sr : {y, sr[WIDTH-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_ADD;
         sa    <= '0;
         sb    <= '0;
         sr    <= '0;
         run_c <= 1'b0;
         out_q <= '0;
      end else if (launch) begin
         op_q  <= op_in;
         sa    <= opa;
         sb    <= opb;
         run_c <= cin0;
         sr    <= op_is_shl(op_in) ? {opa[WIDTH-2:0], 1'b0} : '0;
      end else if (busy) begin
         sa    <= sa >> 1;
         sb    <= sb >> 1;
         run_c <= cout;
         if (!op_is_shl(op_q)) sr <= {y, sr[WIDTH-1:1]};
         if (last) out_q <= fin;
      end
   end

   bsalu_flags #(.WIDTH(WIDTH), .ZERO_SERIAL(ZERO_SERIAL)) u_flags (
      .clk(clk), .rst_n(rst_n), .launch(launch), .step(busy), .last(last),
      .done_i(done), .op_q(op_q), .bit_in(y), .final_res(fin), .c_new(cout),
      .carry_q(carry_flag), .zero_q(zero_flag), .neg_q(neg_flag)
   );

   assign result = out_q;

   assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (zero_flag == (result == '0)));
   assert_neg_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (neg_flag == result[WIDTH-1]));
   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
   assert_logic_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_is_logic(op_q)) |-> $stable(carry_flag));
   assert_shl_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_is_shl(op_q)) |-> (result[0] == 1'b0));

endmodule

// File: tb/sim_bsalu_core.sv
module sim_bsalu_core;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [2:0]   op = 3'd0;
   logic [W-1:0] opa = '0, opb = '0;
   logic [W-1:0] result;
   logic         done, busy, carry_flag, zero_flag, neg_flag;

   int checks = 0;
   int failures = 0;
   int m_c = 0;
   int m_res = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   bsalu_core #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
      .result(result), .done(done), .busy(busy), .carry_flag(carry_flag),
      .zero_flag(zero_flag), .neg_flag(neg_flag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string req_of(input int o);
      case (o)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4, 5: return "R6";
         default: return "R7";
      endcase
   endfunction

   // Reference model: computes the expected result and the new carry.
   task automatic model(input int o, input int a, input int b, output int res, output int c);
      int s;
      c = m_c;
      case (o)
         0: begin s = a + b;              res = s & 255; c = (s >> 8) & 1; end
         1: begin s = a + b + m_c;        res = s & 255; c = (s >> 8) & 1; end
         2: begin s = a + (~b & 255) + 1; res = s & 255; c = (s >> 8) & 1; end
         3: begin s = a + (~b & 255) + m_c; res = s & 255; c = (s >> 8) & 1; end
         4: res = a & b;
         5: res = a | b;
         default: begin res = (a << 1) & 255; c = (a >> 7) & 1; end
      endcase
   endtask

   // Runs one operation; when intr is set a second start arrives mid-flight (R11).
   task automatic run_op(input int o, input int a, input int b, input bit intr);
      int er, ec, prev_res, prev_c;
      string rq;
      rq = req_of(o);
      model(o, a, b, er, ec);
      prev_res = m_res;
      prev_c = m_c;
      op = 3'(o); opa = W'(a); opb = W'(b); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      op = 3'(~o); opa = W'(~a); opb = W'(~b);
      for (int i = 1; i <= W + 1; i++) begin
         @(negedge clk);
         if (intr && i == 4) begin
            chk(busy == 1'b1, "R11", busy, 1);
            start = 1'b0;
         end
         if (i < W) begin
            chk(done == 1'b0 && busy == 1'b1, "R1", {busy, done}, 2);
            chk(result == W'(prev_res) && carry_flag == prev_c[0], "R10",
                result, prev_res);
         end else if (i == W) begin
            chk(done == 1'b1 && busy == 1'b0, "R1", {busy, done}, 1);
            chk(result == W'(er), rq, result, er);
            chk(carry_flag == ec[0], rq, carry_flag, ec);
            chk(zero_flag == (er == 0), "R8", zero_flag, er == 0);
            chk(neg_flag == er[7], "R9", neg_flag, er[7]);
         end else begin
            chk(done == 1'b0, "R1", done, 0);
         end
         if (intr && i == 3) begin
            start = 1'b1; op = 3'd4; opa = 8'h00; opb = 8'h00;
         end
      end
      m_c = ec;
      m_res = er;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(result == '0 && {done, busy, carry_flag, zero_flag, neg_flag} == 5'b0,
          "R12", {result, done, busy, carry_flag, zero_flag, neg_flag}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R12", {busy, done}, 0);

      run_op(0, 8'h35, 8'h4A, 1'b0);   // R2 plain add
      run_op(0, 8'hFF, 8'h01, 1'b0);   // R2 carry out, R8 zero
      run_op(1, 8'h10, 8'h20, 1'b0);   // R3 uses carry = 1
      run_op(2, 8'h05, 8'h03, 1'b0);   // R4 no borrow
      run_op(2, 8'h03, 8'h05, 1'b0);   // R4 borrow, R9 negative
      run_op(3, 8'h10, 8'h01, 1'b0);   // R5 uses carry = 0
      run_op(3, 8'h10, 8'h01, 1'b0);   // R5 uses carry = 1
      run_op(5, 8'hA7, 8'h00, 1'b0);   // R6 OR with zero passes opa
      run_op(4, 8'hF0, 8'h3C, 1'b0);   // R6 AND, carry kept
      run_op(6, 8'h81, 8'h55, 1'b0);   // R7 shift, carry = top bit
      run_op(7, 8'h40, 8'hFF, 1'b0);   // R7 alternate code, opb ignored
      run_op(0, 8'h12, 8'h34, 1'b1);   // R11 start while busy ignored
      begin
         int lf = 8'h5B;
         for (int k = 0; k < 60; k++) begin
            int a, b;
            lf = ((lf << 1) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1)) & 255;
            a = lf;
            lf = ((lf << 1) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1)) & 255;
            b = lf;
            run_op(k % 8, a, b, 1'b0);
         end
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule